// File: doc/BRIEF.md
# Speculative Access Conflict Tracker

This block keeps one tracking flag per cache block, held next to the tag array. It detects when a speculatively executed critical section loses atomicity. While speculation is active, every load or store the core performs marks the flag of the block it touches. Marking also starts earlier, from the moment a candidate lock-acquire store is reported. From that point on, every following access is marked, even though some of them may lie outside the critical section. Coherence snoops are looked up against the flags in the same cycle as their tag check. A conflict sends a misspeculation pulse to the elision controller.

A conflict is any of the following:
- an invalidating snoop to a marked block;
- any snoop at all to a marked block that is held exclusive;
- an uncached access during speculation;
- the eviction of a marked block, since that block can no longer be watched.

Commit or abort clears every flag at once. The tag and data arrays, the coherence state machine and the decision to elide are all outside this block. The block only receives the current exclusive/non-exclusive state of the snooped block as an input.

Top module: `spec_access_tracker`

## Requirements
- R1: A cached access (`acc_valid`=1, `acc_uncached`=0) sets the flag of block `acc_idx` when tracking is on, which is when `spec_active`=1 or the block is armed. An access made while tracking is off sets no flag.
- R2: A snoop with `snp_inv`=1 to a block whose flag is set raises `misspec`.
- R3: A snoop of any kind with `snp_excl`=1 to a block whose flag is set raises `misspec`.
- R4: A snoop with `snp_inv`=0 and `snp_excl`=0 does not raise `misspec`. Neither does any snoop to a block whose flag is clear.
- R5: The flag lookup happens in the snoop's own cycle, so `misspec` is high exactly in the cycle after the offending event.
- R6: `commit` or `abort` clears all flags on the next edge. The clear wins over a same-cycle set, and an event in the same cycle as `commit` or `abort` raises nothing.
- R7: A `cand_acq` pulse arms tracking for the accesses that follow it, even before `spec_active` rises. The armed state lasts until `commit` or `abort`.
- R8: An uncached access (`acc_valid`=1, `acc_uncached`=1) during speculation raises `misspec`.
- R9: An eviction (`evict_valid`=1) of a block whose flag is set raises `misspec`. Evicting an unflagged block raises nothing.
- R10: `misspec` is a one-cycle pulse. After it fires, further conflicts are ignored until the next `commit` or `abort`.
- R11: `misspec` stays low for any event seen while `spec_active`=0.
- R12: After reset, `misspec` is 0 and every flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_active | input | 1 | Speculative critical section in progress |
| cand_acq | input | 1 | Candidate acquire store seen; arms tracking |
| acc_valid | input | 1 | Local load or store this cycle |
| acc_idx | input | $clog2(NBLK) | Block touched by the local access |
| acc_uncached | input | 1 | Local access bypasses the cache |
| evict_valid | input | 1 | A block is being evicted |
| evict_idx | input | $clog2(NBLK) | Block being evicted |
| snp_valid | input | 1 | External snoop request this cycle |
| snp_idx | input | $clog2(NBLK) | Block hit by the snoop |
| snp_inv | input | 1 | Snoop invalidates the block |
| snp_excl | input | 1 | Snooped block is currently in exclusive state |
| commit | input | 1 | Speculation committed; clear all flags |
| abort | input | 1 | Speculation aborted; clear all flags |
| misspec | output | 1 | One-cycle misspeculation pulse |

## Verification
Every result of this block is due one edge after its cause. A flag set by an access can be hit from the next cycle on. A conflicting snoop, eviction or uncached access shows on `misspec` in the following cycle. A commit or abort leaves all flags clear from the following cycle on. The bench drives inputs just after a falling edge and compares `misspec` at the next falling edge with a behavioural model that steps at the same rising edge. The latency check samples both the cycle of the snoop, where `misspec` must still be low, and the cycle after, where it must be high.

// File: rtl/spec_access_tracker.sv
module spec_access_tracker #(
  parameter int NBLK = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spec_active,
  input  logic                    cand_acq,
  input  logic                    acc_valid,
  input  logic [$clog2(NBLK)-1:0] acc_idx,
  input  logic                    acc_uncached,
  input  logic                    evict_valid,
  input  logic [$clog2(NBLK)-1:0] evict_idx,
  input  logic                    snp_valid,
  input  logic [$clog2(NBLK)-1:0] snp_idx,
  input  logic                    snp_inv,
  input  logic                    snp_excl,
  input  logic                    commit,
  input  logic                    abort,
  output logic                    misspec
);
  logic [NBLK-1:0] abit;
  logic armed, flagged;
  logic clr, track, mark, snp_hit, evict_hit, unc_hit, raise;

  assign clr       = commit | abort;
  assign track     = spec_active | armed;
  assign mark      = acc_valid & ~acc_uncached & track;
  assign snp_hit   = snp_valid & abit[snp_idx] & (snp_inv | snp_excl);
  assign evict_hit = evict_valid & abit[evict_idx];
  assign unc_hit   = acc_valid & acc_uncached;
  assign raise     = spec_active & ~flagged & ~clr & (snp_hit | evict_hit | unc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)     abit <= '0;
    else if (clr)   abit <= '0;
    else if (mark)  abit[acc_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      flagged <= 1'b0;
      misspec <= 1'b0;
    end else begin
      armed   <= clr ? 1'b0 : (armed | cand_acq);
      flagged <= clr ? 1'b0 : (flagged | raise);
      misspec <= raise;
    end
  end
endmodule

module spec_access_tracker_chk #(
  parameter int NBLK = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    spec_active,
  input logic                    acc_valid,
  input logic [$clog2(NBLK)-1:0] acc_idx,
  input logic                    acc_uncached,
  input logic                    snp_valid,
  input logic [$clog2(NBLK)-1:0] snp_idx,
  input logic                    snp_inv,
  input logic                    commit,
  input logic                    abort,
  input logic                    armed,
  input logic                    flagged,
  input logic [NBLK-1:0]         abit,
  input logic                    misspec
);
  a_r1_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_uncached && (spec_active || armed) && !commit && !abort)
      |=> abit[$past(acc_idx)]);

  a_r2_inval_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_active && snp_valid && snp_inv && abit[snp_idx] && !flagged && !commit && !abort)
      |=> misspec);

  a_r6_flash_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |=> (abit == '0 && !armed));

  a_r8_uncached: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_active && acc_valid && acc_uncached && !flagged && !commit && !abort) |=> misspec);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    misspec |=> !misspec);

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_active |=> !misspec);
endmodule

bind spec_access_tracker spec_access_tracker_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .spec_active(spec_active), .acc_valid(acc_valid),
  .acc_idx(acc_idx), .acc_uncached(acc_uncached), .snp_valid(snp_valid),
  .snp_idx(snp_idx), .snp_inv(snp_inv), .commit(commit), .abort(abort),
  .armed(armed), .flagged(flagged), .abit(abit), .misspec(misspec)
);

// File: tb/sim_spec_access_tracker.sv
`timescale 1ns/100ps
module sim_spec_access_tracker;
  localparam int NBLK = 64;
  localparam int IW = $clog2(NBLK);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec_active, cand_acq, acc_valid, acc_uncached, evict_valid;
  logic snp_valid, snp_inv, snp_excl, commit, abort;
  logic [IW-1:0] acc_idx, evict_idx, snp_idx;
  logic misspec;

  int checks = 0;
  int fails = 0;
  string tag = "R12";
  bit done = 0;

  always #2.5 clk = ~clk;

  spec_access_tracker #(.NBLK(NBLK)) u0 (
    .clk(clk), .rst_n(rst_n), .spec_active(spec_active), .cand_acq(cand_acq),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_uncached(acc_uncached),
    .evict_valid(evict_valid), .evict_idx(evict_idx), .snp_valid(snp_valid),
    .snp_idx(snp_idx), .snp_inv(snp_inv), .snp_excl(snp_excl),
    .commit(commit), .abort(abort), .misspec(misspec)
  );

  bit mbits[NBLK];
  bit marm, mflag, mexp;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mbits[i]) mbits[i] = 0;
      marm = 0; mflag = 0; mexp = 0;
    end else begin
      bit conflict, r;
      bit clear_now;
      clear_now = commit || abort;
      conflict = 0;
      if (snp_valid && mbits[snp_idx] && (snp_inv || snp_excl)) conflict = 1;
      if (evict_valid && mbits[evict_idx]) conflict = 1;
      if (acc_valid && acc_uncached) conflict = 1;
      r = spec_active && !mflag && !clear_now && conflict;
      if (clear_now) begin
        foreach (mbits[i]) mbits[i] = 0;
        marm = 0; mflag = 0;
      end else begin
        if (acc_valid && !acc_uncached && (spec_active || marm)) mbits[acc_idx] = 1;
        if (cand_acq) marm = 1;
        if (r) mflag = 1;
      end
      mexp = r;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (misspec !== mexp) begin
        fails++;
        $display("FAIL %s model compare: misspec=%0b expected=%0b at %0t", tag, misspec, mexp, $time);
      end
    end
  end

  task automatic clr_in();
    spec_active = 0; cand_acq = 0; acc_valid = 0; acc_uncached = 0; evict_valid = 0;
    snp_valid = 0; snp_inv = 0; snp_excl = 0; commit = 0; abort = 0;
    acc_idx = '0; evict_idx = '0; snp_idx = '0;
  endtask

  task automatic step();
    @(negedge clk);
    cand_acq = 0; acc_valid = 0; acc_uncached = 0; evict_valid = 0;
    snp_valid = 0; snp_inv = 0; snp_excl = 0; commit = 0; abort = 0;
  endtask

  task automatic chk(input string t, input logic exp);
    checks++;
    if (misspec !== exp) begin
      fails++;
      $display("FAIL %s: misspec=%0b expected=%0b at %0t", t, misspec, exp, $time);
    end
  endtask

  task automatic access(input int idx);
    acc_valid = 1; acc_idx = IW'(idx); step();
  endtask

  task automatic snoop(input int idx, input logic inv, input logic ex);
    snp_valid = 1; snp_idx = IW'(idx); snp_inv = inv; snp_excl = ex; step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    clr_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R12", 0);
    tag = "R12"; spec_active = 1;
    snoop(5, 1, 1); chk("R12", 0);
    snoop(0, 1, 1); chk("R12", 0);
    commit = 1; step();

    tag = "R2"; access(3);
    snoop(3, 1, 0); chk("R2", 1);
    step(); chk("R10", 0);
    commit = 1; step();

    tag = "R4"; access(7);
    snoop(7, 0, 0); chk("R4", 0);
    snoop(8, 1, 1); chk("R4", 0);
    abort = 1; step();

    tag = "R3"; access(9);
    snoop(9, 0, 1); chk("R3", 1);
    commit = 1; step();

    tag = "R10"; access(1); access(2);
    snoop(1, 1, 0); chk("R10", 1);
    snoop(2, 1, 0); chk("R10", 0);
    commit = 1; step();
    tag = "R6"; snoop(1, 1, 1); chk("R6", 0);
    access(2); snoop(2, 1, 0); chk("R6", 1);
    commit = 1; step();

    access(4);
    snp_valid = 1; snp_idx = IW'(4); snp_inv = 1; commit = 1; step(); chk("R6", 0);
    snoop(4, 1, 1); chk("R6", 0);
    acc_valid = 1; acc_idx = IW'(20); abort = 1; step();
    snoop(20, 1, 1); chk("R6", 0);

    tag = "R1"; spec_active = 0; access(6);
    spec_active = 1; snoop(6, 1, 1); chk("R1", 0);
    tag = "R7"; spec_active = 0; cand_acq = 1; step();
    access(11);
    tag = "R11"; snoop(11, 1, 1); chk("R11", 0);
    tag = "R7"; spec_active = 1; snoop(11, 1, 0); chk("R7", 1);
    commit = 1; step();
    spec_active = 0; access(11); spec_active = 1;
    snoop(11, 1, 1); chk("R7", 0);

    tag = "R8"; acc_valid = 1; acc_uncached = 1; acc_idx = IW'(30); step(); chk("R8", 1);
    commit = 1; step();
    snoop(30, 1, 1); chk("R8", 0);

    tag = "R9"; access(12);
    evict_valid = 1; evict_idx = IW'(13); step(); chk("R9", 0);
    evict_valid = 1; evict_idx = IW'(12); step(); chk("R9", 1);
    commit = 1; step();

    tag = "R5"; access(40);
    snp_valid = 1; snp_idx = IW'(40); snp_inv = 1;
    chk("R5", 0);
    step(); chk("R5", 1);
    commit = 1; step();

    tag = "R11"; access(50); spec_active = 0;
    snoop(50, 1, 1); chk("R11", 0);
    evict_valid = 1; evict_idx = IW'(50); step(); chk("R11", 0);
    spec_active = 1; snoop(50, 0, 1); chk("R3", 1);
    commit = 1; step();

    tag = "R10";
    for (int n = 0; n < 4000; n++) begin
      int p;
      p = $urandom_range(0, 99);
      spec_active = (p < 85);
      cand_acq = ($urandom_range(0, 49) == 0);
      acc_valid = ($urandom_range(0, 2) == 0);
      acc_idx = IW'($urandom_range(0, 15));
      acc_uncached = ($urandom_range(0, 39) == 0);
      evict_valid = ($urandom_range(0, 19) == 0);
      evict_idx = IW'($urandom_range(0, 15));
      snp_valid = ($urandom_range(0, 3) == 0);
      snp_idx = IW'($urandom_range(0, 15));
      snp_inv = $urandom_range(0, 1);
      snp_excl = ($urandom_range(0, 3) == 0);
      commit = ($urandom_range(0, 29) == 0);
      abort = ($urandom_range(0, 59) == 0);
      step();
    end
    clr_in();
    step();
    finish_run();
  end
endmodule